// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Flush and Targeted Invalidate

This block keeps a small set of recent virtual-to-physical page mappings so that most memory accesses skip the page-table walk. A lookup presents a virtual page number, the page offset and an access kind. In that same cycle, with no register on the path, the block compares the page number against every resident entry. It returns hit or miss, the physical page number, the physical address (the cached page number joined to the untranslated offset), and the entry's read, write, execute and dirty flags.

When a lookup misses, an external walker fetches the page-table entry and installs it through the fill port, and the requester then retries. A store that finds a resident entry whose dirty flag is clear is turned into a miss. The walker can then mark the page dirty in memory and refill the entry. A one-cycle flush drops every mapping, for use when the page-table base changes. A targeted invalidate drops the mapping of one virtual page after its page-table entry has been edited. Victims are chosen with invalid entries first, then by least-recent use.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is resident: every lookup reports a miss with all data outputs at zero.
- R2: A lookup whose page number matches a resident entry reports, in the same cycle, a hit, that entry's physical page number and its four flags. The physical address is formed as {physical page, offset}.
- R3: When the lookup strobe is low, or no resident entry matches, the hit output and all of page number, address and flags read zero.
- R4: Access kinds are encoded 2'b00 load, 2'b01 store, 2'b10 fetch, and 2'b11 is treated as a load. A store that matches an entry with its dirty flag clear is reported as a miss. Loads and fetches hit whatever the permission flags say.
- R5: A fill becomes visible to lookups from the next cycle. A fill for a page that is already resident overwrites that entry in place, so no page is ever held twice and the other entries are left unchanged.
- R6: A fill for a non-resident page takes the lowest-numbered invalid entry if one exists. Otherwise it replaces the least recently used entry. Here "use" means a fill, or a lookup that hits in a cycle with no fill and no flush.
- R7: A flush makes every entry invalid from the next cycle. A fill in the same cycle as a flush is dropped.
- R8: A targeted invalidate removes only the entry holding that page. For a page that is not resident it changes neither the contents nor the replacement order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_ofs | input | OFS_W | Page offset, passed through untranslated |
| lk_kind | input | 2 | Access kind (load, store, fetch) |
| lk_hit | output | 1 | Translation found and usable |
| lk_ppn | output | PPN_W | Physical page number on hit |
| lk_paddr | output | PPN_W+OFS_W | Physical address on hit |
| lk_rd | output | 1 | Entry read permission |
| lk_wr | output | 1 | Entry write permission |
| lk_ex | output | 1 | Entry execute permission |
| lk_dirty | output | 1 | Entry dirty flag |
| fill_valid | input | 1 | Install a walked entry |
| fill_vpn | input | VPN_W | Virtual page of the installed entry |
| fill_ppn | input | PPN_W | Physical page of the installed entry |
| fill_rd | input | 1 | Read permission to install |
| fill_wr | input | 1 | Write permission to install |
| fill_ex | input | 1 | Execute permission to install |
| fill_dirty | input | 1 | Dirty flag to install |
| flush | input | 1 | Drop all entries |
| inv_valid | input | 1 | Drop one entry |
| inv_vpn | input | VPN_W | Virtual page to drop |

## Verification
The bench uses a four-entry build and, after every operation, sweeps every virtual page under all four access kinds. This catches a stale mapping, and it catches a page that is held twice after a dirty refill, which would leave a clean copy shadowing the dirty one. Long fill sequences over more pages than there are entries expose a victim choice that ignores recency: it evicts a just-touched page, and a later sweep then misses on it. They also expose a victim choice that overwrites a valid entry while an invalid one is free. Flushes issued together with a fill would reveal a design that lets the fill survive, because that page would still hit. Invalidates of absent pages would reveal one that disturbs the replacement order, because a later fill would evict the wrong page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic dirty;
  } pflags_t;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned AGE_W   = 4,
  parameter int unsigned SLOT_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_we,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  pflags_t          fill_flags,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             touch_any,
  input  logic             touch_me,
  input  logic [AGE_W-1:0] touch_age,
  output logic             valid_o,
  output logic             lk_match_o,
  output logic             fill_match_o,
  output logic [AGE_W-1:0] age_o,
  output logic [PPN_W-1:0] ppn_o,
  output pflags_t          flags_o
);

  logic             valid_q, valid_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  pflags_t          flags_q;
  logic             inv_hit;

  assign inv_hit      = inv_valid && valid_q && (vpn_q == inv_vpn);
  assign lk_match_o   = valid_q && (vpn_q == lk_vpn);
  assign fill_match_o = valid_q && (vpn_q == fill_vpn);
  assign valid_o      = valid_q;
  assign age_o        = age_q;
  assign ppn_o        = ppn_q;
  assign flags_o      = flags_q;

  always_comb begin
    valid_d = valid_q;
    if (flush)        valid_d = 1'b0;
    else if (fill_we) valid_d = 1'b1;
    else if (inv_hit) valid_d = 1'b0;
  end

  always_comb begin
    age_d = age_q;
    if (touch_any) begin
      if (touch_me)               age_d = '0;
      else if (age_q < touch_age) age_d = AGE_W'(age_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      age_q   <= AGE_W'(SLOT_ID);
    end else begin
      valid_q <= valid_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      vpn_q   <= fill_vpn;
      ppn_q   <= fill_ppn;
      flags_q <= fill_flags;
    end
  end

  // R5
  fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (valid_q && vpn_q == $past(fill_vpn)));

  // R8
  inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hit && !fill_we && !flush) |=> !valid_q);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned AGE_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0]            fmatch_vec,
  input  logic [ENTRIES-1:0][AGE_W-1:0] ages,
  output logic [ENTRIES-1:0]            sel
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  always_comb begin
    sel = '0;
    if (|fmatch_vec) begin
      sel = fmatch_vec;
    end else if (!(&valid_vec)) begin
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (!valid_vec[i]) begin
          sel    = '0;
          sel[i] = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ages[i] == OLDEST) sel[i] = 1'b1;
      end
    end
  end

  // R6
  one_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);

  // R6
  prefer_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&valid_vec) && !(|fmatch_vec)) |-> ((sel & valid_vec) == '0));

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned OFS_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFS_W-1:0]       lk_ofs,
  input  logic [1:0]             lk_kind,
  output logic                   lk_hit,
  output logic [PPN_W-1:0]       lk_ppn,
  output logic [PPN_W+OFS_W-1:0] lk_paddr,
  output logic                   lk_rd,
  output logic                   lk_wr,
  output logic                   lk_ex,
  output logic                   lk_dirty,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  input  logic                   fill_ex,
  input  logic                   fill_dirty,
  input  logic                   flush,
  input  logic                   inv_valid,
  input  logic [VPN_W-1:0]       inv_vpn
);

  localparam int unsigned     AGE_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]            valid_vec, match_vec, fmatch_vec, sel_vec;
  logic [ENTRIES-1:0]            touch_vec, oldest_vec;
  logic [ENTRIES-1:0][AGE_W-1:0] ages;
  logic [ENTRIES-1:0][PPN_W-1:0] ppns;
  pflags_t [ENTRIES-1:0]         flags;

  pflags_t          fill_flags, hit_flags;
  logic [PPN_W-1:0] hit_ppn;
  logic [AGE_W-1:0] touch_age;
  logic             any_match, store_clean, hit_int, touch_any, do_fill;
  acc_e             kind;

  assign fill_flags = '{rd: fill_rd, wr: fill_wr, ex: fill_ex, dirty: fill_dirty};
  assign kind       = acc_e'(lk_kind);
  assign do_fill    = fill_valid && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .AGE_W(AGE_W), .SLOT_ID(g)
    ) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .fill_we      (do_fill && sel_vec[g]),
      .fill_vpn     (fill_vpn),
      .fill_ppn     (fill_ppn),
      .fill_flags   (fill_flags),
      .inv_valid    (inv_valid),
      .inv_vpn      (inv_vpn),
      .lk_vpn       (lk_vpn),
      .touch_any    (touch_any),
      .touch_me     (touch_vec[g]),
      .touch_age    (touch_age),
      .valid_o      (valid_vec[g]),
      .lk_match_o   (match_vec[g]),
      .fill_match_o (fmatch_vec[g]),
      .age_o        (ages[g]),
      .ppn_o        (ppns[g]),
      .flags_o      (flags[g])
    );
    assign oldest_vec[g] = (ages[g] == OLDEST);
  end

  tlb_victim #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .fmatch_vec (fmatch_vec),
    .ages       (ages),
    .sel        (sel_vec)
  );

  // Read mux: tags are unique, so an OR over the matching entry suffices.
  always_comb begin
    hit_ppn   = '0;
    hit_flags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_ppn   = hit_ppn | ppns[i];
        hit_flags = pflags_t'(hit_flags | flags[i]);
      end
    end
  end

  assign any_match   = |match_vec;
  assign store_clean = (kind == ACC_STORE) && !hit_flags.dirty;
  assign hit_int     = lk_valid && any_match && !store_clean;

  assign lk_hit   = hit_int;
  assign lk_ppn   = hit_int ? hit_ppn : '0;
  assign lk_paddr = hit_int ? {hit_ppn, lk_ofs} : '0;
  assign lk_rd    = hit_int && hit_flags.rd;
  assign lk_wr    = hit_int && hit_flags.wr;
  assign lk_ex    = hit_int && hit_flags.ex;
  assign lk_dirty = hit_int && hit_flags.dirty;

  // Recency update: a fill outranks a concurrent hit; a flush freezes order.
  assign touch_any = !flush && (fill_valid || hit_int);
  assign touch_vec = fill_valid ? sel_vec : match_vec;

  always_comb begin
    touch_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (touch_vec[i]) touch_age = touch_age | ages[i];
    end
  end

  // R5
  dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  // R6
  oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_paddr == '0));

  // R4
  clean_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && kind == ACC_STORE) |-> lk_dirty);

endmodule

// File: tb/sim_tlb_fa.sv
`timescale 1ns/1ps
module sim_tlb_fa;
  localparam int N  = 4;
  localparam int VW = 6;
  localparam int PW = 6;
  localparam int OW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          lk_valid;
  logic [VW-1:0] lk_vpn;
  logic [OW-1:0] lk_ofs;
  logic [1:0]    lk_kind;
  logic          lk_hit;
  logic [PW-1:0] lk_ppn;
  logic [PW+OW-1:0] lk_paddr;
  logic          lk_rd, lk_wr, lk_ex, lk_dirty;
  logic          fill_valid;
  logic [VW-1:0] fill_vpn;
  logic [PW-1:0] fill_ppn;
  logic          fill_rd, fill_wr, fill_ex, fill_dirty;
  logic          flush;
  logic          inv_valid;
  logic [VW-1:0] inv_vpn;

  tlb_fa #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .OFS_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ofs(lk_ofs), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_paddr(lk_paddr),
    .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_ex(lk_ex), .lk_dirty(lk_dirty),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_dirty(fill_dirty),
    .flush(flush), .inv_valid(inv_valid), .inv_vpn(inv_vpn)
  );

  int vectors = 0;
  int errs    = 0;
  bit done    = 1'b0;

  // Reference state: flags packed {rd, wr, ex, dirty}
  bit            m_v   [N];
  logic [VW-1:0] m_vpn [N];
  logic [PW-1:0] m_ppn [N];
  logic [3:0]    m_f   [N];
  int            m_t   [N];
  int            tick = 0;
  logic [15:0]   lf = 16'hACE1;

  function automatic int find(input logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int victim(input logic [VW-1:0] v);
    int s;
    int best;
    s = find(v);
    if (s >= 0) return s;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    best = 0;
    for (int i = 1; i < N; i++) if (m_t[i] < m_t[best]) best = i;
    return best;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  task automatic check_one(input string tag, input logic [VW-1:0] v,
                           input logic [1:0] k, input logic lv);
    int s;
    bit eh;
    string t;
    logic [1+PW+PW+OW+4-1:0] exp_v, act_v;
    lk_valid = lv; lk_vpn = v; lk_kind = k; lk_ofs = OW'(v + k);
    #0.001;
    s  = find(v);
    eh = lv && (s >= 0) && !(k == 2'b01 && !m_f[s][0]);
    t  = tag;
    if (lv && s >= 0 && k == 2'b01 && !m_f[s][0]) t = "R4";
    else if (eh && tag != "R1") t = "R2";
    exp_v = eh ? {1'b1, m_ppn[s], m_ppn[s], OW'(v + k), m_f[s]} : '0;
    act_v = {lk_hit, lk_ppn, lk_paddr, lk_rd, lk_wr, lk_ex, lk_dirty};
    vectors++;
    if (act_v !== exp_v) begin
      errs++;
      $display("FAIL %s vpn=%0d kind=%0d valid=%0b actual=%h expected=%h",
               t, v, k, lv, act_v, exp_v);
    end
  endtask

  // Sweep every page and kind; called just after a falling edge.
  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << VW); v++)
      for (int k = 0; k < 4; k++)
        check_one(tag, VW'(v), 2'(k), 1'b1);
    for (int i = 0; i < N; i++)
      if (m_v[i]) check_one("R3", m_vpn[i], 2'b00, 1'b0);
    lk_valid = 1'b0;
  endtask

  task automatic idle_inputs();
    lk_valid = 0; fill_valid = 0; flush = 0; inv_valid = 0;
  endtask

  task automatic tick_edge(input string tag);
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    sweep(tag);
  endtask

  task automatic op_fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                         input logic [3:0] f, input bit with_flush);
    int s;
    fill_valid = 1; fill_vpn = v; fill_ppn = p;
    {fill_rd, fill_wr, fill_ex, fill_dirty} = f;
    flush = with_flush;
    if (with_flush) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      s = victim(v);
      m_v[s] = 1; m_vpn[s] = v; m_ppn[s] = p; m_f[s] = f;
      tick++; m_t[s] = tick;
    end
    tick_edge(with_flush ? "R7" : "R5");
  endtask

  task automatic op_look(input logic [VW-1:0] v, input logic [1:0] k);
    int s;
    lk_valid = 1; lk_vpn = v; lk_kind = k; lk_ofs = '0;
    s = find(v);
    if (s >= 0 && !(k == 2'b01 && !m_f[s][0])) begin
      tick++; m_t[s] = tick;
    end
    tick_edge("R6");
  endtask

  task automatic op_inv(input logic [VW-1:0] v);
    int s;
    inv_valid = 1; inv_vpn = v;
    s = find(v);
    if (s >= 0) m_v[s] = 0;
    tick_edge("R8");
  endtask

  task automatic op_flush();
    flush = 1;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    tick_edge("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = 0; end
    idle_inputs();
    lk_vpn = '0; lk_ofs = '0; lk_kind = '0;
    fill_vpn = '0; fill_ppn = '0; inv_vpn = '0;
    {fill_rd, fill_wr, fill_ex, fill_dirty} = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1");

    // R6: free slots first, then least recently used
    op_fill(6'd1, 6'd11, 4'b1001, 0);
    op_fill(6'd2, 6'd12, 4'b1100, 0);
    op_fill(6'd3, 6'd13, 4'b0010, 0);
    op_fill(6'd4, 6'd14, 4'b1111, 0);
    op_look(6'd1, 2'b00);
    op_fill(6'd5, 6'd15, 4'b1000, 0);
    op_look(6'd3, 2'b10);
    op_fill(6'd6, 6'd16, 4'b0001, 0);

    // R4 and R5: clean store misses, dirty refill in place
    op_fill(6'd7, 6'd17, 4'b1100, 0);
    op_look(6'd7, 2'b01);
    op_fill(6'd7, 6'd17, 4'b1101, 0);
    op_look(6'd7, 2'b01);

    // R8: absent page leaves order intact; present page is dropped
    op_inv(6'd60);
    op_fill(6'd8, 6'd18, 4'b1001, 0);
    op_inv(6'd7);
    op_fill(6'd9, 6'd19, 4'b0101, 0);

    // R7: flush alone and flush with a fill
    op_flush();
    op_fill(6'd10, 6'd20, 4'b1111, 1);
    op_fill(6'd10, 6'd21, 4'b1111, 0);

    for (int n = 0; n < 300; n++) begin
      logic [VW-1:0] v;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v = (lf[7:4] == 4'hF) ? VW'(lf[13:8]) : VW'((lf[7:4] % 7) + 1);
      case (lf[2:0])
        3'd0, 3'd1, 3'd2: op_fill(v, PW'(lf[15:10]), lf[11:8], 0);
        3'd3, 3'd4:       op_look(v, lf[9:8]);
        3'd5:             op_inv(v);
        3'd6:             if (lf[8] && lf[9]) op_flush(); else op_look(v, 2'b01);
        default:          if (lf[10]) op_fill(v, PW'(lf[15:10]), lf[11:8], 1);
                          else op_fill(v, PW'(lf[14:9]), 4'b1111, 0);
      endcase
    end

    finish_run();
  end

endmodule